// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects a wide set of level-sensitive interrupt lines and hands each one to one of four processor cores on one of four interrupt pins. Sources are arranged in groups of 32. Each source has a sampled level and an enable bit. A source that is enabled and has been raised becomes active. Every active source appears in the status word of the core it is routed to. It also drives the output line for its core and pin pair.

Software reaches the block through a 32-bit register port. Writes take effect at the next rising clock edge. Reads are combinational from the address.

The register regions are:

| Region | Offsets | Content |
|---|---|---|
| Node descriptor | 0x000 to 0x01F | 8 words, stored only |
| Pin route | 0x040 to 0x047 | 2 words |
| Enable | 0x080 to 0x09F | 8 words |
| Bounce | 0x0C0 to 0x0DF | 8 words, stored only |
| Core status | 0x400 to 0x7FF | one status region per core |
| Core route | 0x800 to 0x8FF | 64 words |

A routing byte names its target by the position of its lowest set bit. Any unusable position falls back to target 0. Routes, enables and status clears act on live interrupts at once: a source that is already active follows a route change to the new core, and it drops out when it is masked or cleared.

Top module: `route_intc`

## Requirements
- R1: Source n is controlled by bit n%32 of the enable word at offset 0x080 + 4*(n/32), which reads back as written.
- R2: Group g (sources 32g to 32g+31) takes its pin from byte g%4 (little-endian) of the word at 0x040 + 4*(g/4). The pin index is the position of the lowest set bit of that byte, and a zero byte or a position of 4 or more selects pin 0. The word reads back as written.
- R3: Source n takes its core from byte n%4 (little-endian) of the word at 0x800 + 4*(n/4), decoded the same way as the pin byte. A zero byte or a position of 4 or more selects core 0. The word reads back as written.
- R4: A source input that rises while its enable bit is clear sets no status bit and drives no output. If the enable bit is later set while the input is still high, the source becomes active on the clock edge that takes the write.
- R5: Clearing an enable bit withdraws an active source from its core status and from its output on the edge that takes the write.
- R6: Output irq_o[c*4+p] is high while at least one active source is routed to core c and pin p. It falls only when the last such source goes inactive.
- R7: In 0x400 to 0x7FF, the core is addr[9:8] and the group word is addr[4:2]. The other address bits are ignored. A read returns bit n%32 set for each active source of that group routed to that core. Writing 1 to a bit clears that source if it is routed to that core, and bits written as 0 or routed elsewhere are untouched.
- R8: Rewriting the core byte of an active source moves its status bit and its output to the new core on the next edge. Rewriting a route with its current value changes nothing.
- R9: A source becomes active only on a rising input, or on an enable rising while the input is high. A falling input withdraws the source. An input held high after its status was cleared is not delivered again.
- R10: The node descriptor words and the bounce words read back what was written, and writing them has no effect on any output.
- R11: Reads from offsets outside every region return 0. Writes there change no register and no output.
- R12: Reset clears every register, every sampled level and every active source, so irq_o is 0 and every route points to core 0 and pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 256 | Level-sensitive interrupt inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_o | output | 16 | Per core and pin level outputs, bit c*4+p |

## Verification
The bound checker covers four invariants on every cycle:
- an active source always has its enable bit and its sampled level set;
- no source turns active without its input being high;
- a falling input always removes the source;
- the outputs stay low when nothing is active, and never outnumber the active sources.

Only the bench scenarios can show the things that depend on software values:
- the byte decode of routes and its fallback to 0;
- the move of a live source to a new core;
- write-one-to-clear restricted to the addressed core;
- sharing of one output by several sources;
- readback of stored-only and unmapped offsets.

// File: rtl/route_intc_pkg.sv
package route_intc_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int ROUTE_W     = 2;
    localparam int NODE_WORDS  = 8;

    localparam int NODE_BASE   = 'h000;
    localparam int PIN_BASE    = 'h040;
    localparam int EN_BASE     = 'h080;
    localparam int BOUNCE_BASE = 'h0C0;
    localparam int STAT_BASE   = 'h400;
    localparam int STAT_SPAN   = 'h400;
    localparam int CORE_BASE   = 'h800;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_NODE,
        RG_PIN,
        RG_EN,
        RG_BOUNCE,
        RG_STAT,
        RG_CORE
    } region_e;

    // Position of the lowest set bit; zero byte or position >= lim gives 0.
    function automatic int route_idx(input logic [7:0] b, input int lim);
        int pos;
        pos = 8;
        for (int i = 7; i >= 0; i--) begin
            if (b[i]) pos = i;
        end
        return (pos < lim) ? pos : 0;
    endfunction

endpackage

// File: rtl/route_intc_regs.sv
module route_intc_regs
    import route_intc_pkg::*;
#(
    parameter int NSRC  = 256,
    parameter int NCORE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NCORE*NSRC-1:0]   status_i,
    output logic [DATA_W-1:0]       rdata,
    output logic [NSRC-1:0]         en_q,
    output logic [NSRC-1:0]         en_d,
    output logic [NSRC/4-1:0]       pin_bytes,
    output logic [NSRC*8-1:0]       core_bytes,
    output logic                    st_clr,
    output logic [1:0]              st_core,
    output logic [2:0]              st_word
);

    localparam int NGRP       = NSRC / 32;
    localparam int PIN_WORDS  = (NGRP + 3) / 4;
    localparam int CMAP_WORDS = NSRC / 4;

    logic [DATA_W-1:0] node_q [NODE_WORDS];
    logic [DATA_W-1:0] pin_q  [PIN_WORDS];
    logic [DATA_W-1:0] en_w   [NGRP];
    logic [DATA_W-1:0] bnc_q  [NGRP];
    logic [DATA_W-1:0] cmap_q [CMAP_WORDS];
    logic [PIN_WORDS*32-1:0] pin_flat;

    region_e region;
    int      a;
    int      idx;

    // Region decode
    always_comb begin
        a      = {{(32-ADDR_W){1'b0}}, addr};
        region = RG_NONE;
        idx    = 0;
        if (a < NODE_BASE + 4*NODE_WORDS) begin
            region = RG_NODE;
            idx    = (a - NODE_BASE) >> 2;
        end else if (a >= PIN_BASE && a < PIN_BASE + 4*PIN_WORDS) begin
            region = RG_PIN;
            idx    = (a - PIN_BASE) >> 2;
        end else if (a >= EN_BASE && a < EN_BASE + 4*NGRP) begin
            region = RG_EN;
            idx    = (a - EN_BASE) >> 2;
        end else if (a >= BOUNCE_BASE && a < BOUNCE_BASE + 4*NGRP) begin
            region = RG_BOUNCE;
            idx    = (a - BOUNCE_BASE) >> 2;
        end else if (a >= STAT_BASE && a < STAT_BASE + STAT_SPAN) begin
            region = RG_STAT;
        end else if (a >= CORE_BASE && a < CORE_BASE + 4*CMAP_WORDS) begin
            region = RG_CORE;
            idx    = (a - CORE_BASE) >> 2;
        end
    end

    // Next enable value, seen by the tracker in the same cycle
    for (genvar g = 0; g < NGRP; g++) begin : g_en
        assign en_d[g*32 +: 32] = (we && region == RG_EN && idx == g) ? wdata : en_w[g];
        assign en_q[g*32 +: 32] = en_w[g];
    end

    for (genvar w = 0; w < PIN_WORDS; w++) begin : g_pin
        assign pin_flat[w*32 +: 32] = pin_q[w];
    end
    assign pin_bytes = pin_flat[NSRC/4-1:0];

    for (genvar w = 0; w < CMAP_WORDS; w++) begin : g_cmap
        assign core_bytes[w*32 +: 32] = cmap_q[w];
    end

    assign st_clr  = we && (region == RG_STAT);
    assign st_core = addr[9:8];
    assign st_word = addr[4:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NODE_WORDS; w++) node_q[w] <= '0;
            for (int w = 0; w < PIN_WORDS; w++)  pin_q[w]  <= '0;
            for (int w = 0; w < NGRP; w++)       en_w[w]   <= '0;
            for (int w = 0; w < NGRP; w++)       bnc_q[w]  <= '0;
            for (int w = 0; w < CMAP_WORDS; w++) cmap_q[w] <= '0;
        end else begin
            for (int w = 0; w < NGRP; w++) en_w[w] <= en_d[w*32 +: 32];
            if (we) begin
                unique case (region)
                    RG_NODE: begin
                        for (int w = 0; w < NODE_WORDS; w++)
                            if (idx == w) node_q[w] <= wdata;
                    end
                    RG_PIN: begin
                        for (int w = 0; w < PIN_WORDS; w++)
                            if (idx == w) pin_q[w] <= wdata;
                    end
                    RG_BOUNCE: begin
                        for (int w = 0; w < NGRP; w++)
                            if (idx == w) bnc_q[w] <= wdata;
                    end
                    RG_CORE: begin
                        for (int w = 0; w < CMAP_WORDS; w++)
                            if (idx == w) cmap_q[w] <= wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        unique case (region)
            RG_NODE: begin
                for (int w = 0; w < NODE_WORDS; w++)
                    if (idx == w) rdata = node_q[w];
            end
            RG_PIN: begin
                for (int w = 0; w < PIN_WORDS; w++)
                    if (idx == w) rdata = pin_q[w];
            end
            RG_EN: begin
                for (int w = 0; w < NGRP; w++)
                    if (idx == w) rdata = en_w[w];
            end
            RG_BOUNCE: begin
                for (int w = 0; w < NGRP; w++)
                    if (idx == w) rdata = bnc_q[w];
            end
            RG_STAT: begin
                for (int c = 0; c < NCORE; c++)
                    for (int g = 0; g < NGRP; g++)
                        if (st_core == c[1:0] && st_word == g[2:0])
                            rdata = status_i[c*NSRC + g*32 +: 32];
            end
            RG_CORE: begin
                for (int w = 0; w < CMAP_WORDS; w++)
                    if (idx == w) rdata = cmap_q[w];
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/route_intc_track.sv
module route_intc_track
    import route_intc_pkg::*;
#(
    parameter int NSRC = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         src_i,
    input  logic [NSRC-1:0]         en_q,
    input  logic [NSRC-1:0]         en_d,
    input  logic [ROUTE_W*NSRC-1:0] core_sel,
    input  logic                    st_clr,
    input  logic [1:0]              st_core,
    input  logic [2:0]              st_word,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NSRC-1:0]         act_q,
    output logic [NSRC-1:0]         raw_q
);

    logic [NSRC-1:0] w1c;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic [NSRC-1:0] act_d;

    // Status clear hits only sources routed to the addressed core
    for (genvar n = 0; n < NSRC; n++) begin : g_w1c
        localparam logic [2:0] GW = 3'(n / 32);
        localparam int         BP = n % 32;
        assign w1c[n] = st_clr && (st_word == GW) && wdata[BP]
                        && (core_sel[ROUTE_W*n +: ROUTE_W] == st_core);
    end

    // Delivery on a rising input or on an enable turning on under a high input
    assign set_v = en_d & src_i & (~raw_q | ~en_q);
    // Withdrawal on a falling input, a cleared enable or a status clear
    assign clr_v = (raw_q & ~src_i) | (en_q & ~en_d) | w1c;
    assign act_d = (act_q & ~clr_v) | set_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            raw_q <= '0;
        end else begin
            act_q <= act_d;
            raw_q <= src_i;
        end
    end

endmodule

// File: rtl/route_intc_route.sv
module route_intc_route
    import route_intc_pkg::*;
#(
    parameter int NSRC  = 256,
    parameter int NCORE = 4,
    parameter int NPIN  = 4
) (
    input  logic [NSRC-1:0]         act_q,
    input  logic [NSRC*8-1:0]       core_bytes,
    input  logic [NSRC/4-1:0]       pin_bytes,
    output logic [ROUTE_W*NSRC-1:0] core_sel,
    output logic [NCORE*NSRC-1:0]   status_o,
    output logic [NCORE*NPIN-1:0]   irq_o
);

    localparam int NGRP = NSRC / 32;

    logic [ROUTE_W*NGRP-1:0] pin_sel;
    logic [NCORE*NGRP-1:0]   grp_any;

    for (genvar g = 0; g < NGRP; g++) begin : g_pin
        assign pin_sel[ROUTE_W*g +: ROUTE_W] = ROUTE_W'(route_idx(pin_bytes[8*g +: 8], NPIN));
    end

    for (genvar n = 0; n < NSRC; n++) begin : g_core
        assign core_sel[ROUTE_W*n +: ROUTE_W] = ROUTE_W'(route_idx(core_bytes[8*n +: 8], NCORE));
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_stc
        for (genvar n = 0; n < NSRC; n++) begin : g_stn
            assign status_o[c*NSRC + n] = act_q[n] && (core_sel[ROUTE_W*n +: ROUTE_W] == ROUTE_W'(c));
        end
        for (genvar g = 0; g < NGRP; g++) begin : g_any
            assign grp_any[c*NGRP + g] = |status_o[c*NSRC + g*32 +: 32];
        end
    end

    // One output per core and pin: OR over the groups routed to that pin
    for (genvar c = 0; c < NCORE; c++) begin : g_oc
        for (genvar p = 0; p < NPIN; p++) begin : g_op
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int g = 0; g < NGRP; g++)
                    if (grp_any[c*NGRP + g] && pin_sel[ROUTE_W*g +: ROUTE_W] == ROUTE_W'(p))
                        hit = 1'b1;
            end
            assign irq_o[c*NPIN + p] = hit;
        end
    end

endmodule

// File: rtl/route_intc.sv
module route_intc
    import route_intc_pkg::*;
#(
    parameter int NSRC  = 256,
    parameter int NCORE = 4,
    parameter int NPIN  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_i,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NCORE*NPIN-1:0] irq_o
);

    logic [NSRC-1:0]         en_q;
    logic [NSRC-1:0]         en_d;
    logic [NSRC/4-1:0]       pin_bytes;
    logic [NSRC*8-1:0]       core_bytes;
    logic [ROUTE_W*NSRC-1:0] core_sel;
    logic [NCORE*NSRC-1:0]   status;
    logic                    st_clr;
    logic [1:0]              st_core;
    logic [2:0]              st_word;
    logic [NSRC-1:0]         act_q;
    logic [NSRC-1:0]         raw_q;

    route_intc_regs #(.NSRC(NSRC), .NCORE(NCORE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .status_i   (status),
        .rdata      (reg_rdata),
        .en_q       (en_q),
        .en_d       (en_d),
        .pin_bytes  (pin_bytes),
        .core_bytes (core_bytes),
        .st_clr     (st_clr),
        .st_core    (st_core),
        .st_word    (st_word)
    );

    route_intc_track #(.NSRC(NSRC)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .en_q     (en_q),
        .en_d     (en_d),
        .core_sel (core_sel),
        .st_clr   (st_clr),
        .st_core  (st_core),
        .st_word  (st_word),
        .wdata    (reg_wdata),
        .act_q    (act_q),
        .raw_q    (raw_q)
    );

    route_intc_route #(.NSRC(NSRC), .NCORE(NCORE), .NPIN(NPIN)) u_route (
        .act_q      (act_q),
        .core_bytes (core_bytes),
        .pin_bytes  (pin_bytes),
        .core_sel   (core_sel),
        .status_o   (status),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/route_intc_chk.sv
module route_intc_chk #(
    parameter int NSRC = 256,
    parameter int NOUT = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_i,
    input logic [NOUT-1:0] irq_o,
    input logic [NSRC-1:0] act,
    input logic [NSRC-1:0] raw,
    input logic [NSRC-1:0] en
);

    // R5: an active source always has its enable bit set
    p_act_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act & ~en) == '0);

    // R9: an active source always has its sampled level high
    p_act_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act & ~raw) == '0);

    // R4: a source turns active only if its input was high at that edge
    p_rise_needs_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((act & ~$past(act) & ~$past(src_i)) == '0));

    // R9: a falling input removes the source
    p_fall_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((act & $past(raw) & ~$past(src_i)) == '0));

    // R6: no output without an active source
    p_idle_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (irq_o == '0));

    // R6: each raised output needs at least one active source of its own
    p_out_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_o) <= $countones(act));

endmodule

bind route_intc route_intc_chk #(.NSRC(NSRC), .NOUT(NCORE*NPIN)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .irq_o (irq_o),
    .act   (act_q),
    .raw   (raw_q),
    .en    (en_q)
);

// File: tb/route_intc_tb.sv
module route_intc_tb;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_SET = 2'd2;
    localparam logic [1:0] OP_CLR = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [15:0] irq;
        logic [31:0] rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VECS [0:NV-1] = '{
        '{OP_RD,  12'h080, 32'h0,        16'h0000, 32'h0,        4'd12}, // R12 reset
        '{OP_SET, 12'd5,   32'h0,        16'h0000, 32'h0,        4'd4},  // R4 disabled rise
        '{OP_RD,  12'h400, 32'h0,        16'h0000, 32'h0,        4'd4},  // R4 no status
        '{OP_WR,  12'h080, 32'h20,       16'h0001, 32'h0,        4'd4},  // R4 enable delivers
        '{OP_RD,  12'h400, 32'h0,        16'h0001, 32'h20,       4'd7},  // R7 status read
        '{OP_RD,  12'h080, 32'h0,        16'h0001, 32'h20,       4'd1},  // R1 enable readback
        '{OP_WR,  12'h804, 32'h400,      16'h0100, 32'h0,        4'd8},  // R8 move to core2
        '{OP_RD,  12'h400, 32'h0,        16'h0100, 32'h0,        4'd8},  // R8 old core empty
        '{OP_RD,  12'h600, 32'h0,        16'h0100, 32'h20,       4'd7},  // R7 new core status
        '{OP_WR,  12'h040, 32'h08,       16'h0800, 32'h0,        4'd2},  // R2 pin3
        '{OP_WR,  12'h040, 32'h10,       16'h0100, 32'h0,        4'd2},  // R2 pos4 -> pin0
        '{OP_WR,  12'h040, 32'h06,       16'h0200, 32'h0,        4'd2},  // R2 lowest bit -> pin1
        '{OP_SET, 12'd40,  32'h0,        16'h0200, 32'h0,        4'd4},  // R4
        '{OP_WR,  12'h084, 32'h100,      16'h0201, 32'h0,        4'd1},  // R1 group1 bit8
        '{OP_WR,  12'h828, 32'h04,       16'h0300, 32'h0,        4'd3},  // R3 source40 core2
        '{OP_WR,  12'h040, 32'h0206,     16'h0200, 32'h0,        4'd6},  // R6 shared output
        '{OP_RD,  12'h604, 32'h0,        16'h0200, 32'h100,      4'd7},  // R7 word index
        '{OP_CLR, 12'd5,   32'h0,        16'h0200, 32'h0,        4'd6},  // R6 other still active
        '{OP_CLR, 12'd40,  32'h0,        16'h0000, 32'h0,        4'd6},  // R6 last one gone
        '{OP_SET, 12'd40,  32'h0,        16'h0200, 32'h0,        4'd9},  // R9 rising delivers
        '{OP_WR,  12'h604, 32'h100,      16'h0000, 32'h0,        4'd7},  // R7 w1c
        '{OP_RD,  12'h604, 32'h0,        16'h0000, 32'h0,        4'd7},  // R7
        '{OP_WR,  12'h828, 32'h04,       16'h0000, 32'h0,        4'd8},  // R8 same route
        '{OP_CLR, 12'd40,  32'h0,        16'h0000, 32'h0,        4'd9},  // R9
        '{OP_SET, 12'd40,  32'h0,        16'h0200, 32'h0,        4'd9},  // R9
        '{OP_WR,  12'h404, 32'hFFFFFFFF, 16'h0200, 32'h0,        4'd7},  // R7 other core
        '{OP_WR,  12'h604, 32'h000000FF, 16'h0200, 32'h0,        4'd7},  // R7 zero bits
        '{OP_WR,  12'h084, 32'h0,        16'h0000, 32'h0,        4'd5},  // R5 mask
        '{OP_RD,  12'h604, 32'h0,        16'h0000, 32'h0,        4'd5},  // R5 status gone
        '{OP_WR,  12'h084, 32'h100,      16'h0200, 32'h0,        4'd4},  // R4 re-enable
        '{OP_WR,  12'h828, 32'h80,       16'h0002, 32'h0,        4'd3},  // R3 pos7 -> core0
        '{OP_WR,  12'h828, 32'h30,       16'h0002, 32'h0,        4'd3},  // R3 pos4 -> core0
        '{OP_WR,  12'h828, 32'h0C,       16'h0200, 32'h0,        4'd3},  // R3 pos2
        '{OP_WR,  12'h828, 32'h08,       16'h2000, 32'h0,        4'd3},  // R3 core3
        '{OP_RD,  12'h704, 32'h0,        16'h2000, 32'h100,      4'd7},  // R7 core3
        '{OP_WR,  12'h000, 32'hDEADBEEF, 16'h2000, 32'h0,        4'd10}, // R10 node
        '{OP_RD,  12'h000, 32'h0,        16'h2000, 32'hDEADBEEF, 4'd10}, // R10
        '{OP_WR,  12'h0DC, 32'h12345678, 16'h2000, 32'h0,        4'd10}, // R10 bounce
        '{OP_RD,  12'h0DC, 32'h0,        16'h2000, 32'h12345678, 4'd10}, // R10
        '{OP_WR,  12'h300, 32'hFFFFFFFF, 16'h2000, 32'h0,        4'd11}, // R11 unmapped write
        '{OP_RD,  12'h300, 32'h0,        16'h2000, 32'h0,        4'd11}, // R11 unmapped read
        '{OP_RD,  12'h084, 32'h0,        16'h2000, 32'h100,      4'd11}, // R11 enable intact
        '{OP_RD,  12'h040, 32'h0,        16'h2000, 32'h0206,     4'd2},  // R2 readback
        '{OP_RD,  12'h828, 32'h0,        16'h2000, 32'h08,       4'd3}   // R3 readback
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [255:0] src = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] irq;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    route_intc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic vec_t mk(input logic [1:0] op, input logic [11:0] addr,
                                input logic [31:0] data, input logic [15:0] ei,
                                input logic [31:0] er, input logic [3:0] req);
        vec_t v;
        v.op = op; v.addr = addr; v.data = data; v.irq = ei; v.rd = er; v.req = req;
        return v;
    endfunction

    task automatic apply(input vec_t v);
        reg_addr  = v.addr;
        reg_wdata = v.data;
        reg_we    = (v.op == OP_WR);
        if (v.op == OP_SET) src[v.addr[7:0]] = 1'b1;
        if (v.op == OP_CLR) src[v.addr[7:0]] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        chk(irq == v.irq, int'(v.req), "irq", {16'h0, irq}, {16'h0, v.irq});
        if (v.op == OP_RD)
            chk(reg_rdata == v.rd, int'(v.req), "rdata", reg_rdata, v.rd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 16'h0, 12, "irq after reset R12", {16'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R6/R7: two sources of group 0 on core0, cleared one by one
        apply(mk(OP_SET, 12'd0,   32'h0, 16'h2000, 32'h0, 4'd4));
        apply(mk(OP_SET, 12'd1,   32'h0, 16'h2000, 32'h0, 4'd4));
        apply(mk(OP_WR,  12'h080, 32'h3, 16'h2002, 32'h0, 4'd6));
        apply(mk(OP_RD,  12'h400, 32'h0, 16'h2002, 32'h3, 4'd7));
        apply(mk(OP_WR,  12'h400, 32'h1, 16'h2002, 32'h0, 4'd6));
        apply(mk(OP_RD,  12'h400, 32'h0, 16'h2002, 32'h2, 4'd7));
        apply(mk(OP_WR,  12'h400, 32'h2, 16'h2000, 32'h0, 4'd6));
        // R7: address bits outside [9:8] and [4:2] ignored in the status region
        apply(mk(OP_RD,  12'h7E4, 32'h0, 16'h2000, 32'h100, 4'd7));

        // R12: reset in the middle of traffic
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(irq == 16'h0, 12, "irq in reset R12", {16'h0, irq}, 32'h0);
        rst_n = 1'b1;
        apply(mk(OP_RD, 12'h084, 32'h0, 16'h0, 32'h0, 4'd12));
        apply(mk(OP_RD, 12'h828, 32'h0, 16'h0, 32'h0, 4'd12));
        apply(mk(OP_RD, 12'h040, 32'h0, 16'h0, 32'h0, 4'd12));
        apply(mk(OP_RD, 12'h000, 32'h0, 16'h0, 32'h0, 4'd12));
        apply(mk(OP_RD, 12'h704, 32'h0, 16'h0, 32'h0, 4'd12));

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired: got %0d cycles expected fewer", 50000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule